// File: doc/BRIEF.md
# Multi-Mode Standby Power Controller

This controller moves a peripheral chip into and out of its low-power states and back to normal operation. It supports three states. Hard shutdown turns off the logic supply, and only the saved clock-generation setup is kept. Hard retention stops the internal clocks and keeps the saved state. Soft standby gates only the core clocks.

An external standby pin starts either hard state. The pin passes through a synchronizer, and a retention-select register bit, captured when the pin rises, chooses between the two hard states. A register bit written over the serial interface requests soft standby. A separate inhibit bit blocks entry into every state.

The controller drives these signals:
- the core clock-gate enable,
- the logic power-domain enable,
- the serial-interface enable,
- one-cycle save and restore strobes toward the retention store, each answered by an acknowledge,
- a register-clear strobe used on the power-up-like restart after a shutdown.

It also reports the current state on a 2-bit status output.

Top module: `stby_pwr_ctrl`

## Requirements
- R1: Out of reset the status is 2'b00 (active), clkEn, pwrEn and serialEn are 1, and saveStb, restoreStb and cfgClr are 0.
- R2: A rising edge of standbyPin starts a hard entry. A one-cycle saveStb appears 3 clock cycles after the pin changes, because the pin passes through a two-flop synchronizer and then one controller register. clkEn stays 1 until saveDone is seen. clkEn drops on the cycle after the acknowledge.
- R3: retainSel is captured, through the same synchronizer, at the accepted rising edge of the pin. If it is 1, the block goes to hard retention (status 2'b10) and pwrEn stays 1. If it is 0, the block goes to hard shutdown (status 2'b11) and pwrEn drops one cycle after the clocks are gated. Changing retainSel during standby has no effect on the status or on the exit sequence.
- R4: While inhibit is 1, neither a rising edge of the pin nor softReq starts any entry. Status stays 2'b00 and clkEn stays 1. A pin that is already high when inhibit clears does not start an entry; only a new rising edge does.
- R5: serialEn is 0 from the saveStb cycle of a hard entry until restoreDone completes the exit.
- R6: In hard retention, a falling edge of the pin gives a one-cycle restoreStb 3 cycles later. On that cycle clkEn is 1 and cfgClr is 0.
- R7: In hard shutdown, pwrEn rises 3 cycles after the pin falls, and the clocks stay gated for settleCycles+1 cycles after that. restoreStb and cfgClr then pulse together for one cycle with clkEn at 1. restoreStb therefore appears settleCycles+4 cycles after the pin falls.
- R8: The status changes only when a sequence completes. During a save wait it keeps its previous value. The new hard code appears one cycle after clkEn drops. The status returns to 2'b00 on the cycle after restoreDone is accepted.
- R9: When softReq is 1, not inhibited and the pin is low, status 2'b01 appears one cycle later with clkEn 0, serialEn 1 and pwrEn 1. Clearing softReq returns the block to active (status 2'b00, clkEn 1) one cycle later.
- R10: A synchronized rising edge of the pin during soft standby starts the hard entry sequence. saveStb follows 3 cycles after the pin, and the status then ends at the selected hard code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Active-low reset |
| standbyPin | input | 1 | Asynchronous hard-standby request pin |
| softReq | input | 1 | Soft-standby request register bit |
| retainSel | input | 1 | Retention-select register bit (1 = hard retention) |
| inhibit | input | 1 | Blocks entry into every standby state |
| settleCycles | input | SETTLE_W | Supply settle wait after power-up, in cycles minus one |
| saveDone | input | 1 | Acknowledge from the retention store that the save finished |
| restoreDone | input | 1 | Acknowledge from the retention store that the restore finished |
| clkEn | output | 1 | Core clock-gate enable |
| pwrEn | output | 1 | Logic power-domain enable |
| serialEn | output | 1 | Serial-interface enable |
| saveStb | output | 1 | One-cycle save request |
| restoreStb | output | 1 | One-cycle restore request |
| cfgClr | output | 1 | Clears all registers except clock setup, on restart after shutdown |
| modeStat | output | 2 | 00 active, 01 soft, 10 hard retention, 11 hard shutdown |

## Verification
The bench sweeps both hard states against several settle counts and acknowledge delays. For each combination it computes the cycle of the save strobe and the cycle of the restore strobe. A design with the wrong synchronizer depth or an off-by-one settle count misses these cycles. The bench flips the select bit while the block is in standby, which catches a design that samples the bit as a level instead of capturing it at entry. It also checks the cycle between clock gating and power-off, so a design that drops power with the clocks still running, or that updates the status before the sequence ends, is caught. Separate passes cover inhibit with a pin that stays high after inhibit clears, entry and exit of soft standby, and a pin rise during soft standby, which a design that ignores the pin in that state would never leave.

// File: rtl/stby_pkg.sv
package stby_pkg;

  typedef enum logic [1:0] {
    MODE_ACTIVE = 2'b00,
    MODE_SOFT   = 2'b01,
    MODE_HOLD   = 2'b10,
    MODE_OFF    = 2'b11
  } mode_e;

  typedef enum logic [3:0] {
    S_ACT,
    S_SOFT,
    S_SAVE,
    S_SAVEW,
    S_GATE,
    S_HOLD,
    S_OFF,
    S_SETTLE,
    S_RSTR,
    S_RSTRW
  } state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic  latchKind;
    logic  cntLoad;
    logic  statWr;
    mode_e statVal;
  } dpCmd_t;

endpackage

// File: rtl/stby_sync.sv
module stby_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/stby_dp.sv
module stby_dp
  import stby_pkg::*;
#(
  parameter int SETTLE_W    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                standbyPin,
  input  logic                retainSel,
  input  logic [SETTLE_W-1:0] settleCycles,
  input  dpCmd_t              cmd,
  output logic                stbyLvl,
  output logic                stbyRise,
  output logic                kindOff,
  output logic                cntZero,
  output logic [1:0]          modeStat
);

  logic [1:0]          syncOut;
  logic                retainSync;
  logic                stbyPrev;
  logic [SETTLE_W-1:0] settleCnt;
  mode_e               statReg;

  stby_sync #(.W(2), .STAGES(SYNC_STAGES)) uSync (
    .clk  (clk),
    .rstN (rstN),
    .d    ({retainSel, standbyPin}),
    .q    (syncOut)
  );

  assign stbyLvl    = syncOut[0];
  assign retainSync = syncOut[1];
  assign stbyRise   = stbyLvl & ~stbyPrev;
  assign cntZero    = (settleCnt == '0);
  assign modeStat   = statReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stbyPrev  <= 1'b0;
      kindOff   <= 1'b0;
      settleCnt <= '0;
      statReg   <= MODE_ACTIVE;
    end else begin
      stbyPrev <= stbyLvl;
      if (cmd.latchKind) kindOff <= ~retainSync;
      if (cmd.cntLoad)       settleCnt <= settleCycles;
      else if (!cntZero)     settleCnt <= settleCnt - 1'b1;
      if (cmd.statWr) statReg <= cmd.statVal;
    end
  end

endmodule

// File: rtl/stby_ctrl.sv
module stby_ctrl
  import stby_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   softReq,
  input  logic   inhibit,
  input  logic   saveDone,
  input  logic   restoreDone,
  input  logic   stbyLvl,
  input  logic   stbyRise,
  input  logic   kindOff,
  input  logic   cntZero,
  output dpCmd_t cmd,
  output logic   clkEn,
  output logic   pwrEn,
  output logic   serialEn,
  output logic   saveStb,
  output logic   restoreStb,
  output logic   cfgClr
);

  state_e state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_ACT;
    else       state <= nextState;
  end

  always_comb begin
    nextState     = state;
    cmd.latchKind = 1'b0;
    cmd.cntLoad   = (state != S_SETTLE);
    cmd.statWr    = 1'b0;
    cmd.statVal   = MODE_ACTIVE;
    unique case (state)
      S_ACT: begin
        if (stbyRise && !inhibit) begin
          nextState     = S_SAVE;
          cmd.latchKind = 1'b1;
        end else if (softReq && !inhibit && !stbyLvl) begin
          nextState   = S_SOFT;
          cmd.statWr  = 1'b1;
          cmd.statVal = MODE_SOFT;
        end
      end
      S_SOFT: begin
        if (stbyRise && !inhibit) begin
          nextState     = S_SAVE;
          cmd.latchKind = 1'b1;
        end else if (!softReq) begin
          nextState   = S_ACT;
          cmd.statWr  = 1'b1;
          cmd.statVal = MODE_ACTIVE;
        end
      end
      S_SAVE:  nextState = S_SAVEW;
      S_SAVEW: if (saveDone) nextState = S_GATE;
      S_GATE: begin
        cmd.statWr = 1'b1;
        if (kindOff) begin
          nextState   = S_OFF;
          cmd.statVal = MODE_OFF;
        end else begin
          nextState   = S_HOLD;
          cmd.statVal = MODE_HOLD;
        end
      end
      S_HOLD:   if (!stbyLvl) nextState = S_RSTR;
      S_OFF:    if (!stbyLvl) nextState = S_SETTLE;
      S_SETTLE: if (cntZero)  nextState = S_RSTR;
      S_RSTR:   nextState = S_RSTRW;
      S_RSTRW: begin
        if (restoreDone) begin
          nextState   = S_ACT;
          cmd.statWr  = 1'b1;
          cmd.statVal = MODE_ACTIVE;
        end
      end
      default: nextState = S_ACT;
    endcase
  end

  always_comb begin
    clkEn      = (state == S_ACT) || (state == S_SAVE) || (state == S_SAVEW) ||
                 (state == S_RSTR) || (state == S_RSTRW);
    pwrEn      = (state != S_OFF);
    serialEn   = (state == S_ACT) || (state == S_SOFT);
    saveStb    = (state == S_SAVE);
    restoreStb = (state == S_RSTR);
    cfgClr     = (state == S_RSTR) && kindOff;
  end

endmodule

// File: rtl/stby_pwr_ctrl.sv
module stby_pwr_ctrl
  import stby_pkg::*;
#(
  parameter int SETTLE_W    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                standbyPin,
  input  logic                softReq,
  input  logic                retainSel,
  input  logic                inhibit,
  input  logic [SETTLE_W-1:0] settleCycles,
  input  logic                saveDone,
  input  logic                restoreDone,
  output logic                clkEn,
  output logic                pwrEn,
  output logic                serialEn,
  output logic                saveStb,
  output logic                restoreStb,
  output logic                cfgClr,
  output logic [1:0]          modeStat
);

  dpCmd_t cmd;
  logic   stbyLvl, stbyRise, kindOff, cntZero;

  stby_dp #(.SETTLE_W(SETTLE_W), .SYNC_STAGES(SYNC_STAGES)) uDp (
    .clk          (clk),
    .rstN         (rstN),
    .standbyPin   (standbyPin),
    .retainSel    (retainSel),
    .settleCycles (settleCycles),
    .cmd          (cmd),
    .stbyLvl      (stbyLvl),
    .stbyRise     (stbyRise),
    .kindOff      (kindOff),
    .cntZero      (cntZero),
    .modeStat     (modeStat)
  );

  stby_ctrl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .softReq     (softReq),
    .inhibit     (inhibit),
    .saveDone    (saveDone),
    .restoreDone (restoreDone),
    .stbyLvl     (stbyLvl),
    .stbyRise    (stbyRise),
    .kindOff     (kindOff),
    .cntZero     (cntZero),
    .cmd         (cmd),
    .clkEn       (clkEn),
    .pwrEn       (pwrEn),
    .serialEn    (serialEn),
    .saveStb     (saveStb),
    .restoreStb  (restoreStb),
    .cfgClr      (cfgClr)
  );

endmodule

// File: rtl/stby_chk.sv
module stby_chk (
  input logic       clk,
  input logic       rstN,
  input logic       inhibit,
  input logic       clkEn,
  input logic       pwrEn,
  input logic       serialEn,
  input logic       saveStb,
  input logic       restoreStb,
  input logic       cfgClr,
  input logic [1:0] modeStat
);

  AST_SERIAL_OFF_HARD: assert property (@(posedge clk) disable iff (!rstN)
    modeStat[1] |-> !serialEn); // R5

  AST_PWR_OFF_ONLY_SHUTDOWN: assert property (@(posedge clk) disable iff (!rstN)
    !pwrEn |-> (modeStat == 2'b11 && !clkEn)); // R3

  AST_GATE_BEFORE_PWR_DROP: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pwrEn) |-> !$past(clkEn)); // R3

  AST_SAVE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    saveStb |=> !saveStb); // R2

  AST_RESTORE_CLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    restoreStb |-> (clkEn && pwrEn && !serialEn)); // R6

  AST_CFGCLR_WITH_RESTORE: assert property (@(posedge clk) disable iff (!rstN)
    cfgClr |-> restoreStb); // R7

  AST_INHIBIT_HARD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(saveStb) |-> !$past(inhibit)); // R4

  AST_INHIBIT_SOFT: assert property (@(posedge clk) disable iff (!rstN)
    (modeStat == 2'b01 && $past(modeStat) == 2'b00) |-> !$past(inhibit)); // R4

  AST_STATUS_HELD_AT_SAVE: assert property (@(posedge clk) disable iff (!rstN)
    saveStb |-> $stable(modeStat)); // R8

endmodule

bind stby_pwr_ctrl stby_chk uChk (
  .clk        (clk),
  .rstN       (rstN),
  .inhibit    (inhibit),
  .clkEn      (clkEn),
  .pwrEn      (pwrEn),
  .serialEn   (serialEn),
  .saveStb    (saveStb),
  .restoreStb (restoreStb),
  .cfgClr     (cfgClr),
  .modeStat   (modeStat)
);

// File: tb/sim_stby_pwr_ctrl.sv
module sim_stby_pwr_ctrl;

  localparam int SW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          standbyPin = 1'b0, softReq = 1'b0, retainSel = 1'b0, inhibit = 1'b0;
  logic [SW-1:0] settleCycles = '0;
  logic          saveDone = 1'b0, restoreDone = 1'b0;
  logic          clkEn, pwrEn, serialEn, saveStb, restoreStb, cfgClr;
  logic [1:0]    modeStat;

  int total = 0;
  int fails = 0;

  always #2 clk = ~clk;

  stby_pwr_ctrl #(.SETTLE_W(SW), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rstN(rstN), .standbyPin(standbyPin), .softReq(softReq),
    .retainSel(retainSel), .inhibit(inhibit), .settleCycles(settleCycles),
    .saveDone(saveDone), .restoreDone(restoreDone), .clkEn(clkEn), .pwrEn(pwrEn),
    .serialEn(serialEn), .saveStb(saveStb), .restoreStb(restoreStb),
    .cfgClr(cfgClr), .modeStat(modeStat)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
  endtask

  // full hard entry and exit; retain selects the state, acks delayed by ds/dr (>=1)
  task automatic hardCycle(input bit retain, input int settle, input int ds, input int dr);
    int n;
    int kind;
    kind = retain ? 2 : 3;
    retainSel = retain;
    settleCycles = SW'(settle);
    repeat (4) tick();
    standbyPin = 1'b1;
    n = 0;
    do begin tick(); n++; end while (!saveStb && n < 20);
    chk("R2 save delay", n, 3);
    chk("R2 clocks on at save", int'(clkEn), 1);
    chk("R5 serial off at save", int'(serialEn), 0);
    chk("R8 status held at save", int'(modeStat), 0);
    repeat (ds) tick();
    chk("R2 clocks on while waiting", int'(clkEn), 1);
    saveDone = 1'b1;
    tick();
    saveDone = 1'b0;
    chk("R2 clocks gated after ack", int'(clkEn), 0);
    chk("R3 power still on at gating", int'(pwrEn), 1);
    chk("R8 status not yet updated", int'(modeStat), 0);
    tick();
    chk("R3 hard status", int'(modeStat), kind);
    chk("R3 power per mode", int'(pwrEn), retain ? 1 : 0);
    chk("R5 serial off in standby", int'(serialEn), 0);
    retainSel = ~retain;
    repeat (4) tick();
    chk("R3 select change ignored", int'(modeStat), kind);
    standbyPin = 1'b0;
    n = 0;
    do begin
      tick(); n++;
      if (!retain && n == 3) begin
        chk("R7 power up first", int'(pwrEn), 1);
        chk("R7 clocks gated during settle", int'(clkEn), 0);
      end
    end while (!restoreStb && n < 400);
    chk(retain ? "R6 restore delay" : "R7 restore delay", n, retain ? 3 : 4 + settle);
    chk("R6 clocks on at restore", int'(clkEn), 1);
    chk("R7 register clear on shutdown only", int'(cfgClr), retain ? 0 : 1);
    chk("R5 serial off at restore", int'(serialEn), 0);
    chk("R8 status held at restore", int'(modeStat), kind);
    repeat (dr) tick();
    restoreDone = 1'b1;
    tick();
    restoreDone = 1'b0;
    chk("R8 status back to active", int'(modeStat), 0);
    chk("R5 serial on after wake", int'(serialEn), 1);
    chk("R6 clocks on after wake", int'(clkEn), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    int sv[4];
    int n;
    sv = '{0, 1, 2, 5};
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    chk("R1 status", int'(modeStat), 0);
    chk("R1 clkEn", int'(clkEn), 1);
    chk("R1 pwrEn", int'(pwrEn), 1);
    chk("R1 serialEn", int'(serialEn), 1);
    chk("R1 strobes", int'({saveStb, restoreStb, cfgClr}), 0);

    for (int r = 0; r < 2; r++)
      for (int s = 0; s < 4; s++)
        for (int ds = 1; ds <= 3; ds += 2)
          for (int dr = 1; dr <= 2; dr++)
            hardCycle(bit'(r), sv[s], ds, dr);

    // inhibit blocks hard entry
    inhibit = 1'b1;
    standbyPin = 1'b1;
    n = 0;
    repeat (10) begin tick(); if (saveStb) n++; end
    chk("R4 no save while inhibited", n, 0);
    chk("R4 status active", int'(modeStat), 0);
    chk("R4 clocks on", int'(clkEn), 1);
    inhibit = 1'b0;
    n = 0;
    repeat (8) begin tick(); if (saveStb) n++; end
    chk("R4 high pin needs new edge", n, 0);
    chk("R4 status still active", int'(modeStat), 0);
    standbyPin = 1'b0;
    repeat (4) tick();

    // inhibit blocks soft entry
    inhibit = 1'b1;
    softReq = 1'b1;
    repeat (3) tick();
    chk("R4 soft blocked status", int'(modeStat), 0);
    chk("R4 soft blocked clocks", int'(clkEn), 1);
    softReq = 1'b0;
    inhibit = 1'b0;
    tick();

    // soft standby
    softReq = 1'b1;
    tick();
    chk("R9 soft status", int'(modeStat), 1);
    chk("R9 soft clocks gated", int'(clkEn), 0);
    chk("R9 soft serial on", int'(serialEn), 1);
    chk("R9 soft power on", int'(pwrEn), 1);
    repeat (3) tick();
    chk("R9 soft held", int'(modeStat), 1);
    softReq = 1'b0;
    tick();
    chk("R9 soft exit status", int'(modeStat), 0);
    chk("R9 soft exit clocks", int'(clkEn), 1);

    // pin rise during soft standby
    retainSel = 1'b1;
    softReq = 1'b1;
    repeat (4) tick();
    standbyPin = 1'b1;
    n = 0;
    do begin tick(); n++; end while (!saveStb && n < 20);
    chk("R10 save from soft delay", n, 3);
    chk("R10 status soft during save", int'(modeStat), 1);
    softReq = 1'b0;
    tick();
    saveDone = 1'b1;
    tick();
    saveDone = 1'b0;
    tick();
    chk("R10 hard status from soft", int'(modeStat), 2);
    standbyPin = 1'b0;
    n = 0;
    do begin tick(); n++; end while (!restoreStb && n < 20);
    chk("R10 restore after soft-origin entry", n, 3);
    tick();
    restoreDone = 1'b1;
    tick();
    restoreDone = 1'b0;
    chk("R10 back to active", int'(modeStat), 0);

    summary();
    $finish;
  end

endmodule